// File: doc/BRIEF.md
# Packed Word Transfer FIFOs

This block holds the two data queues that sit between a processor-facing register interface and a serial two-wire byte engine. The transmit queue takes 32-bit words written by software and hands them, oldest first, to the byte engine. The receive queue collects bytes from the engine and assembles them into 32-bit words before storing them. Bytes are packed least-significant byte first. When the engine marks the end of a transfer, a partly filled word is stored as well.

Software sees one control word and one status word. The control word holds a trigger level for each queue and a self-clearing flush bit for each queue. The status word reports the free slots in the transmit queue and the filled slots in the receive queue. Each queue raises a data-request output when its trigger level is reached. Sticky error flags record a write into a full transmit queue and a read from an empty receive queue.

Each flush is run by a small state machine with two named states. `FL_IDLE` moves to `FL_CLEAR` when a control write sets the flush bit. `FL_CLEAR` always returns to `FL_IDLE` on the next clock. While the machine is in `FL_CLEAR`, the flush bit reads back as 1 and the queue is held in clear. The byte-assembly position advances through byte lanes 0 to 3. It returns to lane 0 when a word is stored or when the receive queue is flushed.

Top module: `xfer_fifo_pair`

## Requirements
- R1: After reset, both queues are empty. The control word reads 0, the status word reads 0x80 (8 free, 0 filled), both error flags are 0, `tx_avail` is 0 and `rx_req` is 0.
- R2: Transmit words leave the queue in the order they were written. `tx_rdata` shows the oldest word whenever `tx_avail` is 1. A pop while the queue is empty has no effect.
- R3: The status word carries the transmit free-slot count in bits 7:4 and the receive filled-slot count in bits 3:0. Neither count ever exceeds the depth (8).
- R4: The control word holds the transmit trigger level in bits 7:5 and the receive trigger level in bits 4:2. A control write loads both fields, and they read back unchanged.
- R5: `tx_req` is 1 exactly when the transmit free-slot count is at least the transmit trigger value plus one.
- R6: `rx_req` is 1 exactly when the receive filled-slot count is at least the receive trigger value plus one.
- R7: Four consecutive received bytes form one stored word. The first byte goes in bits 7:0 and the fourth byte in bits 31:24.
- R8: `rx_last` stores the word being assembled, including a byte offered in the same cycle, and leaves the unused upper bytes zero. `rx_last` with no bytes pending stores nothing.
- R9: A write into a full transmit queue discards the word and sets `tx_ovf`. The flag stays set until the next transmit flush.
- R10: A read of an empty receive queue leaves the queue unchanged and sets `rx_unf`. The flag stays set until the next receive flush.
- R11: Writing 1 to control bit 1 (transmit) or bit 0 (receive) starts a flush. The bit reads 1 in the cycle after the write and 0 in the cycle after that. The flushed queue is then empty and its error flag is 0; for receive, the packing position is back at byte 0. The other queue is not affected.
- R12: A receive word completed while the receive queue is full is discarded, and the stored words are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 8 | Control word write data |
| ctrl_rdata | output | 8 | Control word read-back: trigger levels and flush-busy bits |
| stat_rdata | output | 2*CNT_W (8) | Transmit free slots (upper field) and receive filled slots (lower field) |
| tx_wr | input | 1 | Software push into the transmit queue |
| tx_wdata | input | WORD_W | Word to push |
| tx_rd | input | 1 | Byte engine pop from the transmit queue |
| tx_rdata | output | WORD_W | Oldest transmit word |
| tx_avail | output | 1 | Transmit queue holds at least one word |
| rx_byte_vld | input | 1 | A received byte is offered |
| rx_byte | input | 8 | Received byte |
| rx_last | input | 1 | End of transfer: store the partial word |
| rx_rd | input | 1 | Software pop from the receive queue |
| rx_rdata | output | WORD_W | Oldest receive word (0 when the queue is empty) |
| tx_req | output | 1 | Transmit data request |
| rx_req | output | 1 | Receive data request |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| rx_unf | output | 1 | Sticky receive underflow flag |

## Verification
The bench builds the block with its default parameters: 32-bit words and a depth of 8. With this depth, the largest trigger value (7) asks for exactly the full queue. The bench can therefore test the trigger boundary at both ends: all 8 slots free or filled, and one slot short. Filling a queue to its full depth takes only a few dozen cycles, so the bench also exercises overflow, underflow and the discard of a word arriving at a full receive queue, each from both sides.

// File: rtl/xf_pkg.sv
package xf_pkg;
    // Control word layout. The trigger fields and flush bits are decoded here.
    localparam int TRIG_W      = 3;
    localparam int CTL_TX_TRIG = 5;
    localparam int CTL_RX_TRIG = 2;
    localparam int CTL_TX_FL   = 1;
    localparam int CTL_RX_FL   = 0;

    typedef enum logic {
        FL_IDLE  = 1'b0,
        FL_CLEAR = 1'b1
    } flush_state_e;
endpackage

// File: rtl/xf_flush_seq.sv
module xf_flush_seq
    import xf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    flush_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:  if (start) state_d = FL_CLEAR;
            FL_CLEAR: state_d = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy = (state_q == FL_CLEAR);
    end
endmodule

// File: rtl/xf_word_store.sv
module xf_word_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          push,
    input  logic [WIDTH-1:0]              push_data,
    input  logic                          pop,
    output logic [WIDTH-1:0]              head,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          full,
    output logic                          empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count_q;
    logic             push_ok, pop_ok;

    assign full    = (count_q == CNT_W'(DEPTH));
    assign empty   = (count_q == '0);
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign count   = count_q;
    assign head    = empty ? '0 : mem[rd_ptr];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else if (clr) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (pop_ok)  rd_ptr <= nxt(rd_ptr);
            if (push_ok && !pop_ok)      count_q <= count_q + CNT_W'(1);
            else if (pop_ok && !push_ok) count_q <= count_q - CNT_W'(1);
        end
    end

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // R12
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/xf_byte_packer.sv
module xf_byte_packer #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic              last,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_out
);
    localparam int BYTES = WORD_W / 8;
    localparam int POS_W = $clog2(BYTES);

    logic [POS_W-1:0]  pos_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] merged;

    always_comb begin
        merged = acc_q;
        if (byte_vld) merged[int'(pos_q)*8 +: 8] = byte_in;
    end

    assign word_out = merged;
    assign word_vld = (byte_vld && (pos_q == POS_W'(BYTES - 1))) ||
                      (last && (byte_vld || (pos_q != '0)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            acc_q <= '0;
        end else if (clr || word_vld) begin
            pos_q <= '0;
            acc_q <= '0;
        end else if (byte_vld) begin
            pos_q <= pos_q + POS_W'(1);
            acc_q <= merged;
        end
    end

    // R8
    pack_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !clr) |=> (pos_q == '0));
endmodule

// File: rtl/xfer_fifo_pair.sv
module xfer_fifo_pair
    import xf_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr,
    input  logic [7:0]           ctrl_wdata,
    output logic [7:0]           ctrl_rdata,
    output logic [2*CNT_W-1:0]   stat_rdata,
    input  logic                 tx_wr,
    input  logic [WORD_W-1:0]    tx_wdata,
    input  logic                 tx_rd,
    output logic [WORD_W-1:0]    tx_rdata,
    output logic                 tx_avail,
    input  logic                 rx_byte_vld,
    input  logic [7:0]           rx_byte,
    input  logic                 rx_last,
    input  logic                 rx_rd,
    output logic [WORD_W-1:0]    rx_rdata,
    output logic                 tx_req,
    output logic                 rx_req,
    output logic                 tx_ovf,
    output logic                 rx_unf
);
    logic [TRIG_W-1:0] tx_trig_q, rx_trig_q;
    logic              tx_ovf_q, rx_unf_q;
    logic              tx_busy, rx_busy;
    logic [CNT_W-1:0]  tx_count, rx_count, tx_free;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              pk_vld;
    logic [WORD_W-1:0] pk_word;

    xf_flush_seq u_tx_flush (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ctrl_wr && ctrl_wdata[CTL_TX_FL]),
        .busy  (tx_busy)
    );

    xf_flush_seq u_rx_flush (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ctrl_wr && ctrl_wdata[CTL_RX_FL]),
        .busy  (rx_busy)
    );

    xf_word_store #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_tx_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tx_busy),
        .push      (tx_wr),
        .push_data (tx_wdata),
        .pop       (tx_rd),
        .head      (tx_rdata),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    xf_byte_packer #(.WORD_W(WORD_W)) u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_busy),
        .byte_vld (rx_byte_vld),
        .byte_in  (rx_byte),
        .last     (rx_last),
        .word_vld (pk_vld),
        .word_out (pk_word)
    );

    xf_word_store #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_rx_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_busy),
        .push      (pk_vld),
        .push_data (pk_word),
        .pop       (rx_rd),
        .head      (rx_rdata),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_trig_q <= '0;
            rx_trig_q <= '0;
        end else if (ctrl_wr) begin
            tx_trig_q <= ctrl_wdata[CTL_TX_TRIG +: TRIG_W];
            rx_trig_q <= ctrl_wdata[CTL_RX_TRIG +: TRIG_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   tx_ovf_q <= 1'b0;
        else if (tx_busy)             tx_ovf_q <= 1'b0;
        else if (tx_wr && tx_full)    tx_ovf_q <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   rx_unf_q <= 1'b0;
        else if (rx_busy)             rx_unf_q <= 1'b0;
        else if (rx_rd && rx_empty)   rx_unf_q <= 1'b1;
    end

    assign tx_free    = CNT_W'(DEPTH) - tx_count;
    assign ctrl_rdata = {tx_trig_q, rx_trig_q, tx_busy, rx_busy};
    assign stat_rdata = {tx_free, rx_count};
    assign tx_avail   = !tx_empty;
    assign tx_req     = int'(tx_free)  > int'(tx_trig_q);
    assign rx_req     = int'(rx_count) > int'(rx_trig_q);
    assign tx_ovf     = tx_ovf_q;
    assign rx_unf     = rx_unf_q;

    // R11
    tx_flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> (tx_free == CNT_W'(DEPTH)) && !tx_ovf);

    // R11
    rx_flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |=> (rx_count == '0) && !rx_unf);

    // R9
    tx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_full && !tx_busy) |=> tx_ovf);

    // R10
    rx_unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && rx_empty && !rx_busy) |=> rx_unf);
endmodule

// File: tb/test_xfer_fifo_pair.sv
module test_xfer_fifo_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [7:0]  ctrl_rdata;
    logic [7:0]  stat_rdata;
    logic        tx_wr = 1'b0;
    logic [31:0] tx_wdata = '0;
    logic        tx_rd = 1'b0;
    logic [31:0] tx_rdata;
    logic        tx_avail;
    logic        rx_byte_vld = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_last = 1'b0;
    logic        rx_rd = 1'b0;
    logic [31:0] rx_rdata;
    logic        tx_req, rx_req, tx_ovf, rx_unf;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] tx_exp[$];
    logic [31:0] rx_exp[$];

    always #2 clk = ~clk;

    xfer_fifo_pair i_xfer_fifo_pair (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .stat_rdata(stat_rdata), .tx_wr(tx_wr),
        .tx_wdata(tx_wdata), .tx_rd(tx_rd), .tx_rdata(tx_rdata),
        .tx_avail(tx_avail), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
        .rx_last(rx_last), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .tx_req(tx_req), .rx_req(rx_req), .tx_ovf(tx_ovf), .rx_unf(rx_unf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ctrl_write(input logic [7:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    // Driver: pushes the word and records it as expected when accepted.
    task automatic tx_put(input logic [31:0] w, input bit accept);
        tx_wr = 1'b1; tx_wdata = w;
        if (accept) tx_exp.push_back(w);
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    // Monitor: compares the head against the scoreboard, then pops.
    task automatic tx_take(input string req);
        logic [31:0] e;
        e = tx_exp.pop_front();
        chk(req, tx_rdata, e);
        tx_rd = 1'b1;
        @(negedge clk);
        tx_rd = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] b, input bit vld, input bit last);
        rx_byte_vld = vld; rx_byte = b; rx_last = last;
        @(negedge clk);
        rx_byte_vld = 1'b0; rx_last = 1'b0;
    endtask

    task automatic rx_word(input logic [31:0] w, input bit accept);
        for (int i = 0; i < 4; i++) rx_send(w[i*8 +: 8], 1'b1, 1'b0);
        if (accept) rx_exp.push_back(w);
    endtask

    task automatic rx_take(input string req);
        logic [31:0] e;
        e = rx_exp.pop_front();
        chk(req, rx_rdata, e);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ctrl", ctrl_rdata, 8'h00);
        chk("R1 stat", stat_rdata, 8'h80);
        chk("R1 flags", {tx_ovf, rx_unf, tx_avail, rx_req}, 4'b0000);

        // R4 trigger fields: tx=3, rx=1
        ctrl_write(8'h64);
        chk("R4 readback", ctrl_rdata, 8'h64);

        // R2 pop on empty ignored
        tx_rd = 1'b1; @(negedge clk); tx_rd = 1'b0;
        chk("R2 empty pop", stat_rdata, 8'h80);

        // R2/R3/R5 ordering, counts, trigger
        tx_put(32'hA0000001, 1); tx_put(32'hA0000002, 1); tx_put(32'hA0000003, 1);
        chk("R3 tx free 5", stat_rdata, 8'h50);
        chk("R5 req at 5 free trig 3", tx_req, 1'b1);
        tx_put(32'hA0000004, 1);
        chk("R5 req at 4 free trig 3", tx_req, 1'b1);
        tx_put(32'hA0000005, 1);
        chk("R5 no req at 3 free", tx_req, 1'b0);
        chk("R2 avail", tx_avail, 1'b1);
        for (int i = 0; i < 5; i++) tx_take("R2 order");
        chk("R2 drained", tx_avail, 1'b0);

        // R9 overflow
        for (int i = 0; i < 8; i++) tx_put(32'hB0000000 + i, 1);
        chk("R3 tx free 0", stat_rdata[7:4], 4'd0);
        tx_put(32'hDEADBEEF, 0);
        chk("R9 ovf set", tx_ovf, 1'b1);
        chk("R9 count held", stat_rdata[7:4], 4'd0);
        for (int i = 0; i < 8; i++) tx_take("R9 word dropped");
        chk("R9 ovf sticky", tx_ovf, 1'b1);

        // R7/R6 packing and rx trigger (rx trig 1 -> 2 entries)
        rx_word(32'h44332211, 1);
        chk("R3 rx filled 1", stat_rdata[3:0], 4'd1);
        chk("R6 no req at 1", rx_req, 1'b0);
        rx_word(32'h88776655, 1);
        chk("R6 req at 2", rx_req, 1'b1);

        // R11 tx flush, rx untouched
        tx_put(32'hC0000001, 0); tx_put(32'hC0000002, 0);
        ctrl_write(8'h66);
        chk("R11 tx busy", ctrl_rdata, 8'h66);
        @(negedge clk);
        chk("R11 tx busy cleared", ctrl_rdata, 8'h64);
        chk("R11 tx emptied", stat_rdata, 8'h82);
        chk("R11 tx ovf cleared", tx_ovf, 1'b0);
        rx_take("R7 packed word");
        rx_take("R7 second word");

        // R8 partial words
        rx_send(8'hAA, 1, 0); rx_send(8'hBB, 1, 0);
        rx_send(8'h00, 0, 1);
        rx_exp.push_back(32'h0000BBAA);
        rx_send(8'hCC, 1, 1);
        rx_exp.push_back(32'h000000CC);
        rx_send(8'h00, 0, 1);
        chk("R8 empty last stores nothing", stat_rdata[3:0], 4'd2);
        rx_take("R8 partial two bytes");
        rx_take("R8 byte with last");

        // R10 underflow
        rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
        chk("R10 unf set", rx_unf, 1'b1);
        chk("R10 count held", stat_rdata[3:0], 4'd0);
        @(negedge clk);
        chk("R10 unf sticky", rx_unf, 1'b1);

        // R11 rx flush resets packing position
        rx_send(8'h55, 1, 0);
        ctrl_write(8'h65);
        chk("R11 rx busy", ctrl_rdata, 8'h65);
        @(negedge clk);
        chk("R11 rx busy cleared", ctrl_rdata, 8'h64);
        chk("R11 rx unf cleared", rx_unf, 1'b0);
        rx_word(32'h04030201, 1);
        rx_take("R11 packing restarted");

        // R12 drop when rx full
        for (int i = 0; i < 8; i++) rx_word(32'hE0000000 + i, 1);
        rx_word(32'hFFFFFFFF, 0);
        chk("R12 full count", stat_rdata[3:0], 4'd8);

        // R6 trigger 7 boundary
        ctrl_write(8'h7C);
        chk("R6 req at 8 trig 7", rx_req, 1'b1);
        rx_take("R12 stored words");
        chk("R6 no req at 7 trig 7", rx_req, 1'b0);
        for (int i = 0; i < 7; i++) rx_take("R12 stored words");

        // R5 trigger 7 boundary
        ctrl_write(8'hFC);
        chk("R5 req at 8 free trig 7", tx_req, 1'b1);
        tx_put(32'h12345678, 1);
        chk("R5 no req at 7 free trig 7", tx_req, 1'b0);
        tx_take("R2 single word");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule